// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. Each cycle it presents a byte address to an external instruction store and takes the 32-bit instruction word back in the same cycle. It decodes and executes that word. For loads and stores it drives a data-store port in the same cycle. At the next rising edge it commits the result to its 32 x 32-bit register file and moves to the next program counter.

The instruction words use the common three-format layout:

- a 6-bit opcode in bits 31:26;
- source fields in bits 25:21 and 20:16;
- a destination field in bits 15:11;
- a shift amount in bits 10:6;
- a function code in bits 5:0.

Immediate forms take a 16-bit constant in bits 15:0. Jumps take a 26-bit word index in bits 25:0.

The opcode map is a private variant. Opcode 001001 subtracts an immediate and opcode 001010 is a signed set-less-than with an immediate. The register-indirect jump always goes through register 31, the link register. Both memories live outside the block, and their read paths must be combinational.

Top module: `scCore`

## Requirements
- R1: A synchronous active-high reset loads the PC with 0 and holds it there while reset is high. After release, the first instruction runs from address 0. The PC advances by 4 after every instruction that does not redirect it.
- R2: With opcode 000000, function codes 100000, 100010, 100100, 100101 and 100110 write rs+rt, rs-rt, rs AND rt, rs OR rt and rs XOR rt into rd.
- R3: Opcodes 001000 and 001001 write rs plus, or minus, the sign-extended immediate into rt.
- R4: Opcodes 001100 and 001101 write rs AND, or OR, the zero-extended immediate into rt.
- R5: Function code 101010 (into rd) and opcode 001010 (into rt, with a sign-extended immediate) write 1 when rs is less than the second operand as signed numbers, and 0 otherwise.
- R6: Function codes 000000, 000010 and 000011 shift rt left logically, right logically or right arithmetically by the amount in bits 10:6, and write rd.
- R7: Opcode 100011 loads the word at rs + sign-extended immediate into rt. Opcode 101011 drives that address, drives rt on the write-data bus and sets the write select to 1. The write select is 0 for every other instruction.
- R8: Opcode 000100 (equal) and opcode 000101 (not equal) compare rs with rt. When the branch is taken the PC becomes PC+4 plus the sign-extended offset times 4; otherwise the PC becomes PC+4.
- R9: Opcode 000010 sets the PC to the 26-bit index times 4. Opcode 000011 does the same and also writes PC+4 into register 31.
- R10: Opcode 000000 with function code 001000 loads the PC from register 31, whatever the rs field holds.
- R11: Register 0 always reads 0, and writes aimed at it are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pcOut | output | 32 | Byte address of the current instruction |
| instrIn | input | 32 | Instruction word at pcOut (combinational read) |
| memAddr | output | 32 | Data-store byte address |
| memWrData | output | 32 | Data to store |
| memRdData | input | 32 | Word read at memAddr (combinational read) |
| memWrite | output | 1 | 1 = store memWrData at memAddr, 0 = read |

## Verification
Each instruction's effect on control flow shows on pcOut one cycle later. The bench therefore samples pcOut on every falling edge and compares it with a queued trace, so the PC that follows a jump, a taken branch or a branch that is not taken lands in the slot right after that instruction. Store address, data and select are due combinationally in the same cycle as the store instruction, and are checked on that same falling edge. A register result is visible only from the following cycle, so every register is copied to memory by store instructions near the end of the program, and the stored words are compared with values worked out from the requirements.

// File: rtl/scCorePkg.sv
package scCorePkg;

  localparam int XLEN     = 32;
  localparam int NUM_REGS = 32;
  localparam int REG_AW   = $clog2(NUM_REGS);
  localparam int SHAMT_W  = $clog2(XLEN);
  localparam int IMM_W    = 16;
  localparam int JIDX_W   = 26;
  localparam int LINK_REG = NUM_REGS - 1;

  // opcodes
  localparam logic [5:0] OP_REG  = 6'b000000;
  localparam logic [5:0] OP_ADDI = 6'b001000;
  localparam logic [5:0] OP_SUBI = 6'b001001;
  localparam logic [5:0] OP_SLTI = 6'b001010;
  localparam logic [5:0] OP_ANDI = 6'b001100;
  localparam logic [5:0] OP_ORI  = 6'b001101;
  localparam logic [5:0] OP_LW   = 6'b100011;
  localparam logic [5:0] OP_SW   = 6'b101011;
  localparam logic [5:0] OP_BEQ  = 6'b000100;
  localparam logic [5:0] OP_BNE  = 6'b000101;
  localparam logic [5:0] OP_J    = 6'b000010;
  localparam logic [5:0] OP_JAL  = 6'b000011;

  // function codes for OP_REG
  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_XOR = 6'b100110;
  localparam logic [5:0] FN_SLT = 6'b101010;
  localparam logic [5:0] FN_SLL = 6'b000000;
  localparam logic [5:0] FN_SRL = 6'b000010;
  localparam logic [5:0] FN_SRA = 6'b000011;
  localparam logic [5:0] FN_JR  = 6'b001000;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
    ALU_SLT, ALU_SLL, ALU_SRL, ALU_SRA
  } aluOp_e;

  typedef enum logic [1:0] { DST_RT, DST_RD, DST_LINK } dstSel_e;
  typedef enum logic [1:0] { WB_ALU, WB_MEM, WB_LINK } wbSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    regWrite;
    dstSel_e dstSel;
    wbSel_e  wbSel;
    logic    useImm;
    logic    zeroExt;
    logic    memWrite;
    logic    brEq;
    logic    brNe;
    logic    jump;
    logic    jumpReg;
    aluOp_e  aluOp;
  } ctrl_t;

endpackage

// File: rtl/scRegFile.sv
module scRegFile
  import scCorePkg::*;
#(
  parameter int WIDTH = XLEN,
  parameter int DEPTH = NUM_REGS,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    rdAddrA,
  input  logic [AW-1:0]    rdAddrB,
  output logic [WIDTH-1:0] rdDataA,
  output logic [WIDTH-1:0] rdDataB,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData
);

  logic [WIDTH-1:0] regs [DEPTH];

  // entry 0 is cleared by reset and never written afterwards
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (wrEn && (wrAddr != '0)) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdDataA = regs[rdAddrA];
  assign rdDataB = regs[rdAddrB];

  // R11: register zero reads back as zero on both ports
  a_r11_zero_port_a: assert property (@(posedge clk) disable iff (rst)
    (rdAddrA == '0) |-> (rdDataA == '0));
  a_r11_zero_port_b: assert property (@(posedge clk) disable iff (rst)
    (rdAddrB == '0) |-> (rdDataB == '0));

endmodule

// File: rtl/scAlu.sv
module scAlu
  import scCorePkg::*;
#(
  parameter int WIDTH = XLEN,
  localparam int SW   = $clog2(WIDTH)
) (
  input  aluOp_e           op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic [SW-1:0]    shamt,
  output logic [WIDTH-1:0] y
);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_SLT: y = WIDTH'($signed(a) < $signed(b));
      ALU_SLL: y = b << shamt;
      ALU_SRL: y = b >> shamt;
      ALU_SRA: y = $signed(b) >>> shamt;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/scControl.sv
module scControl
  import scCorePkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (opcode)
      OP_REG: begin
        ctrl.regWrite = 1'b1;
        ctrl.dstSel   = DST_RD;
        unique case (funct)
          FN_ADD: ctrl.aluOp = ALU_ADD;
          FN_SUB: ctrl.aluOp = ALU_SUB;
          FN_AND: ctrl.aluOp = ALU_AND;
          FN_OR:  ctrl.aluOp = ALU_OR;
          FN_XOR: ctrl.aluOp = ALU_XOR;
          FN_SLT: ctrl.aluOp = ALU_SLT;
          FN_SLL: ctrl.aluOp = ALU_SLL;
          FN_SRL: ctrl.aluOp = ALU_SRL;
          FN_SRA: ctrl.aluOp = ALU_SRA;
          FN_JR: begin
            ctrl.regWrite = 1'b0;
            ctrl.jumpReg  = 1'b1;
          end
          default: ctrl.regWrite = 1'b0;
        endcase
      end
      OP_ADDI, OP_SUBI, OP_SLTI, OP_ANDI, OP_ORI: begin
        ctrl.regWrite = 1'b1;
        ctrl.dstSel   = DST_RT;
        ctrl.useImm   = 1'b1;
        ctrl.zeroExt  = (opcode == OP_ANDI) || (opcode == OP_ORI);
        unique case (opcode)
          OP_SUBI: ctrl.aluOp = ALU_SUB;
          OP_SLTI: ctrl.aluOp = ALU_SLT;
          OP_ANDI: ctrl.aluOp = ALU_AND;
          OP_ORI:  ctrl.aluOp = ALU_OR;
          default: ctrl.aluOp = ALU_ADD;
        endcase
      end
      OP_LW: begin
        ctrl.regWrite = 1'b1;
        ctrl.dstSel   = DST_RT;
        ctrl.wbSel    = WB_MEM;
        ctrl.useImm   = 1'b1;
        ctrl.aluOp    = ALU_ADD;
      end
      OP_SW: begin
        ctrl.useImm   = 1'b1;
        ctrl.memWrite = 1'b1;
        ctrl.aluOp    = ALU_ADD;
      end
      OP_BEQ: ctrl.brEq = 1'b1;
      OP_BNE: ctrl.brNe = 1'b1;
      OP_J:   ctrl.jump = 1'b1;
      OP_JAL: begin
        ctrl.jump     = 1'b1;
        ctrl.regWrite = 1'b1;
        ctrl.dstSel   = DST_LINK;
        ctrl.wbSel    = WB_LINK;
      end
      default: ctrl = '0;
    endcase
  end

  // R7: a store never also writes the register file
  a_r7_store_no_regwrite: assert property (@(posedge clk) disable iff (rst)
    ctrl.memWrite |-> !ctrl.regWrite);
  // R7: load write-back and store are mutually exclusive
  a_r7_load_store_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.memWrite, ctrl.wbSel == WB_MEM}));
  // R9: only a jump-and-link targets the link register
  a_r9_link_only_on_jump: assert property (@(posedge clk) disable iff (rst)
    (ctrl.dstSel == DST_LINK) |-> (ctrl.jump && ctrl.regWrite));

endmodule

// File: rtl/scDatapath.sv
module scDatapath
  import scCorePkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [JIDX_W-1:0] instrLow,
  input  logic [XLEN-1:0]   memRdData,
  output logic [XLEN-1:0]   pc,
  output logic [XLEN-1:0]   memAddr,
  output logic [XLEN-1:0]   memWrData
);

  localparam int PAD_J = XLEN - JIDX_W - 2;
  localparam int PAD_I = XLEN - IMM_W;

  logic [REG_AW-1:0]  rsField, rtField, rdField, rdAddrA, wrAddr;
  logic [SHAMT_W-1:0] shamt;
  logic [IMM_W-1:0]   imm;
  logic [XLEN-1:0]    pcPlus4, rsData, rtData, immSext, immZext, aluB, aluY;
  logic [XLEN-1:0]    wrData, brTarget, jTarget, nextPc;
  logic               rsEqRt, brTaken;

  assign rsField = instrLow[25:21];
  assign rtField = instrLow[20:16];
  assign rdField = instrLow[15:11];
  assign shamt   = instrLow[10:6];
  assign imm     = instrLow[IMM_W-1:0];

  assign immSext = {{PAD_I{imm[IMM_W-1]}}, imm};
  assign immZext = {{PAD_I{1'b0}}, imm};
  assign aluB    = ctrl.useImm ? (ctrl.zeroExt ? immZext : immSext) : rtData;

  // register-indirect jump always reads the link register
  assign rdAddrA = ctrl.jumpReg ? REG_AW'(LINK_REG) : rsField;

  scRegFile #(.WIDTH(XLEN), .DEPTH(NUM_REGS)) u_regFile (
    .clk     (clk),
    .rst     (rst),
    .rdAddrA (rdAddrA),
    .rdAddrB (rtField),
    .rdDataA (rsData),
    .rdDataB (rtData),
    .wrEn    (ctrl.regWrite),
    .wrAddr  (wrAddr),
    .wrData  (wrData)
  );

  scAlu #(.WIDTH(XLEN)) u_alu (
    .op    (ctrl.aluOp),
    .a     (rsData),
    .b     (aluB),
    .shamt (shamt),
    .y     (aluY)
  );

  always_comb begin
    unique case (ctrl.dstSel)
      DST_RD:   wrAddr = rdField;
      DST_LINK: wrAddr = REG_AW'(LINK_REG);
      default:  wrAddr = rtField;
    endcase
  end

  always_comb begin
    unique case (ctrl.wbSel)
      WB_MEM:  wrData = memRdData;
      WB_LINK: wrData = pcPlus4;
      default: wrData = aluY;
    endcase
  end

  // next-PC selection
  assign pcPlus4  = pc + XLEN'(4);
  assign brTarget = pcPlus4 + (immSext << 2);
  assign jTarget  = {{PAD_J{1'b0}}, instrLow, 2'b00};
  assign rsEqRt   = (rsData == rtData);
  assign brTaken  = (ctrl.brEq && rsEqRt) || (ctrl.brNe && !rsEqRt);

  always_comb begin
    if (ctrl.jumpReg)   nextPc = rsData;
    else if (ctrl.jump) nextPc = jTarget;
    else if (brTaken)   nextPc = brTarget;
    else                nextPc = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= nextPc;
  end

  assign memAddr   = aluY;
  assign memWrData = rtData;

  // R1: the first cycle after reset executes address 0
  a_r1_pc_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc == '0));
  // R1: straight-line instructions step the PC by one word
  a_r1_sequential_step: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.jump && !ctrl.jumpReg && !ctrl.brEq && !ctrl.brNe)
      |=> (pc == $past(pc) + 32'd4));
  // R8: a taken branch lands on PC+4 plus the scaled offset
  a_r8_branch_target: assert property (@(posedge clk) disable iff (rst)
    ((ctrl.brEq && rsData == rtData) || (ctrl.brNe && rsData != rtData))
      |=> (pc == $past(pc) + 32'd4 +
           {{14{$past(instrLow[15])}}, $past(instrLow[15:0]), 2'b00}));
  // R9: a jump lands on the scaled index
  a_r9_jump_target: assert property (@(posedge clk) disable iff (rst)
    ctrl.jump |=> (pc == {4'b0000, $past(instrLow), 2'b00}));
  // R10: register jump lands on the value that register 31 held
  a_r10_jr_target: assert property (@(posedge clk) disable iff (rst)
    ctrl.jumpReg |=> (pc == $past(rsData)));

endmodule

// File: rtl/scCore.sv
module scCore
  import scCorePkg::*;
(
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] pcOut,
  input  logic [31:0] instrIn,
  output logic [31:0] memAddr,
  output logic [31:0] memWrData,
  input  logic [31:0] memRdData,
  output logic        memWrite
);

  ctrl_t ctrl;

  scControl u_control (
    .clk    (clk),
    .rst    (rst),
    .opcode (instrIn[31:26]),
    .funct  (instrIn[5:0]),
    .ctrl   (ctrl)
  );

  scDatapath u_datapath (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .instrLow  (instrIn[JIDX_W-1:0]),
    .memRdData (memRdData),
    .pc        (pcOut),
    .memAddr   (memAddr),
    .memWrData (memWrData)
  );

  assign memWrite = ctrl.memWrite;

endmodule

// File: tb/test_scCore.sv
`timescale 1ns/1ps
module test_scCore;

  localparam real CLK_PERIOD = 4.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pcOut, instrIn, memAddr, memWrData, memRdData;
  logic        memWrite;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int checks = 0;
  int fails  = 0;
  bit monOn  = 1'b0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] val;
    string       tag;
  } item_t;

  item_t pcQ[$];
  item_t stQ[$];

  always #(CLK_PERIOD / 2.0) clk = ~clk;

  scCore i_scCore (
    .clk       (clk),
    .rst       (rst),
    .pcOut     (pcOut),
    .instrIn   (instrIn),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .memRdData (memRdData),
    .memWrite  (memWrite)
  );

  // external memories: combinational read, store on the rising edge
  assign instrIn   = imem[pcOut[7:2]];
  assign memRdData = dmem[memAddr[7:2]];

  always @(posedge clk) begin
    if (!rst && memWrite) dmem[memAddr[7:2]] <= memWrData;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // ---------------- encoders ----------------
  function automatic logic [31:0] encR(input logic [4:0] rs, input logic [4:0] rt,
      input logic [4:0] rd, input logic [4:0] sh, input logic [5:0] fn);
    return {6'b000000, rs, rt, rd, sh, fn};
  endfunction

  function automatic logic [31:0] encI(input logic [5:0] op, input logic [4:0] rs,
      input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] encJ(input logic [5:0] op, input logic [25:0] idx);
    return {op, idx};
  endfunction

  // ---------------- driver ----------------
  task automatic pushPc(input int idx, input string tag);
    item_t it;
    it.addr = 32'(idx * 4);
    it.val  = 32'(idx * 4);
    it.tag  = tag;
    pcQ.push_back(it);
  endtask

  task automatic pushSt(input logic [31:0] addr, input logic [31:0] val, input string tag);
    item_t it;
    it.addr = addr;
    it.val  = val;
    it.tag  = tag;
    stQ.push_back(it);
  endtask

  localparam int NDUMP = 25;
  int          dumpReg [NDUMP] = '{0,1,2,3,4,5,6,7,8,9,10,11,12,13,14,15,16,17,18,19,20,21,22,23,31};
  logic [31:0] dumpExp [NDUMP] = '{32'd0, 32'd32, 32'd27, 32'd1, 32'd39, 32'd59, 32'd1, 32'd64,
                                   32'd8, 32'd8, 32'hFFFF_FFF0, 32'd5, 32'd3, 32'd63, 32'd60,
                                   32'd18, 32'd31, 32'hFFFF_FFC0, 32'h0000_000F, 32'h0000_FFC0,
                                   32'd0, 32'd1, 32'd0, 32'd27, 32'd60};
  string       dumpTag [NDUMP] = '{"R11", "R3", "R3", "R5", "R7", "R2", "R5", "R6",
                                   "R9", "R6", "R6", "R2", "R2", "R2", "R2",
                                   "R4", "R4", "R3", "R6", "R4",
                                   "R8", "R5", "R5", "R7", "R9"};

  task automatic loadProgram();
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'h0;
    end
    dmem[1] = 32'd39;

    imem[0]  = encI(6'b001000, 0, 1, 16'd32);        // addi r1 = 32           (R3)
    imem[1]  = encI(6'b001001, 1, 2, 16'd5);         // subi r2 = 27           (R3)
    imem[2]  = encI(6'b001010, 0, 3, 16'd32);        // slti r3 = 1            (R5)
    imem[3]  = encI(6'b100011, 0, 4, 16'd4);         // lw r4 = dmem[4]=39     (R7)
    imem[4]  = encI(6'b101011, 0, 1, 16'd0);         // sw r1 -> addr 0        (R7)
    imem[5]  = encR(1, 2, 5, 0, 6'b100000);          // add r5 = 59            (R2)
    imem[6]  = encR(0, 1, 6, 0, 6'b101010);          // slt r6 = 1             (R5)
    imem[7]  = encR(0, 1, 7, 1, 6'b000000);          // sll r7 = 64            (R6)
    imem[8]  = encJ(6'b000010, 26'd13);              // j 13 -> 52             (R9)
    imem[9]  = encI(6'b000100, 7, 7, 16'd1);         // beq taken -> 44        (R8)
    imem[10] = encR(5'd0, 0, 0, 0, 6'b001000);       // jr (r31) -> 60         (R10)
    imem[11] = encI(6'b000101, 1, 0, 16'hFFFE);      // bne taken -> 40        (R8)
    imem[12] = encI(6'b001000, 0, 20, 16'd99);       // skipped                (R8)
    imem[13] = encI(6'b001000, 0, 8, 16'd8);         // addi r8 = 8
    imem[14] = encJ(6'b000011, 26'd9);               // jal 9, r31 = 60        (R9)
    imem[15] = encR(0, 1, 9, 2, 6'b000010);          // srl r9 = 8             (R6)
    imem[16] = encI(6'b001000, 0, 17, 16'hFFC0);     // addi r17 = -64         (R3)
    imem[17] = encR(0, 17, 10, 2, 6'b000011);        // sra r10 = -16          (R6)
    imem[18] = encR(0, 17, 18, 28, 6'b000010);       // srl r18 = 0xF          (R6)
    imem[19] = encR(1, 2, 11, 0, 6'b100010);         // sub r11 = 5            (R2)
    imem[20] = encR(2, 4, 12, 0, 6'b100100);         // and r12 = 3            (R2)
    imem[21] = encR(2, 4, 13, 0, 6'b100101);         // or  r13 = 63           (R2)
    imem[22] = encR(2, 4, 14, 0, 6'b100110);         // xor r14 = 60           (R2)
    imem[23] = encI(6'b001100, 2, 15, 16'd22);       // andi r15 = 18          (R4)
    imem[24] = encI(6'b001101, 2, 16, 16'd22);       // ori  r16 = 31          (R4)
    imem[25] = encI(6'b001100, 17, 19, 16'hFFF0);    // andi r19 = 0xFFC0      (R4)
    imem[26] = encI(6'b001010, 17, 21, 16'hFFFF);    // slti r21 = 1 (signed)  (R5)
    imem[27] = encR(1, 17, 22, 0, 6'b101010);        // slt r22 = 0 (signed)   (R5)
    imem[28] = encI(6'b001000, 0, 0, 16'd5);         // write to r0 discarded  (R11)
    imem[29] = encI(6'b000101, 1, 1, 16'd5);         // bne not taken          (R8)
    imem[30] = encI(6'b000100, 1, 2, 16'd5);         // beq not taken          (R8)
    imem[31] = encI(6'b101011, 9, 2, 16'hFFFC);      // sw r2 -> addr 4        (R7)
    imem[32] = encI(6'b100011, 9, 23, 16'hFFFC);     // lw r23 = 27            (R7)
    for (int j = 0; j < NDUMP; j++)
      imem[33 + j] = encI(6'b101011, 0, 5'(dumpReg[j]), 16'(64 + 4 * j));
    imem[58] = encJ(6'b000010, 26'd58);              // halt loop

    // expected PC trace
    for (int i = 0; i <= 8; i++) pushPc(i, "R1");
    pushPc(13, "R9");
    pushPc(14, "R1");
    pushPc(9,  "R9");
    pushPc(11, "R8");
    pushPc(10, "R8");
    pushPc(15, "R10");
    for (int i = 16; i <= 58; i++) pushPc(i, (i == 30 || i == 31) ? "R8" : "R1");
    for (int i = 0; i < 3; i++) pushPc(58, "R9");

    // expected stores
    pushSt(32'd0, 32'd32, "R7");
    pushSt(32'd4, 32'd27, "R7");
    for (int j = 0; j < NDUMP; j++) pushSt(32'(64 + 4 * j), dumpExp[j], dumpTag[j]);
  endtask

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    if (monOn && !rst) begin
      item_t e;
      if (pcQ.size() != 0) begin
        e = pcQ.pop_front();
        check(pcOut == e.val, e.tag, "pc", pcOut, e.val);
      end
      if (memWrite) begin
        if (stQ.size() == 0) begin
          check(1'b0, "R7", "unexpected store addr", memAddr, 32'hFFFF_FFFF);
        end else begin
          e = stQ.pop_front();
          check(memAddr == e.addr, e.tag, "store addr", memAddr, e.addr);
          check(memWrData == e.val, e.tag, "store data", memWrData, e.val);
        end
      end
      if (pcQ.size() == 0) monOn = 1'b0;
    end
  end

  // ---------------- main ----------------
  initial begin
    loadProgram();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pcOut == 32'd0, "R1", "pc in reset", pcOut, 32'd0);
    check(memWrite == 1'b0, "R7", "write select in reset", 32'(memWrite), 32'd0);

    @(posedge clk);
    #1 rst = 1'b0;
    monOn = 1'b1;
    wait (monOn == 1'b0);

    check(32'(stQ.size()) == 32'd0, "R7", "stores left unseen", 32'(stQ.size()), 32'd0);
    check(dmem[0] == 32'd32, "R7", "dmem word 0", dmem[0], 32'd32);
    check(dmem[1] == 32'd27, "R7", "dmem word 1", dmem[1], 32'd27);

    // reset during a run
    @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(pcOut == 32'd0, "R1", "pc after mid-run reset", pcOut, 32'd0);
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(pcOut == 32'd0, "R1", "pc first cycle after release", pcOut, 32'd0);
    @(negedge clk);
    check(pcOut == 32'd4, "R1", "pc second cycle after release", pcOut, 32'd4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule